// File: doc/BRIEF.md
# Filter Accelerator Control Register

This block is the control register and request logic for a fixed-point filter accelerator that has an input sample buffer (X1) and an output result buffer (Y). Software writes the register through a single-cycle write strobe and can read the current contents at any time. The block combines the enable bits with live buffer-occupancy and error flags. From these it drives one interrupt line, a DMA write request for filling X1 and a DMA read request for draining Y. It also drives the clip-mode select for the accumulator output stage, and a one-cycle unit-clear pulse. The pulse resets the buffer pointers, the status register, the parameter register (START included) and the run control of the accelerator.

Interrupts and DMA requests follow the live flags level for level. They are never latched events. The two DMA enable bits are locked against writes while the parameter register reports a run in progress. A small state machine sequences the self-clearing unit reset. It has two states. ST_IDLE is the normal state and ST_CLEAR is the single pulse cycle. Transition T_HOLD keeps ST_IDLE when no reset write arrives. Transition T_ARM goes from ST_IDLE to ST_CLEAR on a write with the reset bit set. Transition T_DONE always returns from ST_CLEAR to ST_IDLE on the next edge.

Bit layout of the register (bit: meaning): 0 read-interrupt enable, 1 write-interrupt enable, 2 overflow-interrupt enable, 3 underflow-interrupt enable, 4 saturation-interrupt enable, 5 DMA read enable, 6 DMA write enable, 7 clip enable, 8 unit reset. Bits 9 and up are unused.

Top module: `fxa_ctrl`

## Requirements
- R1: With bit 0 set, `irq` is high in every cycle in which `y_empty` is low.
- R2: With bit 1 set, `irq` is high in every cycle in which `x1_full` is low.
- R3: Bits 2, 3 and 4 each raise `irq` only while the matching flag (`ovf_flag`, `unf_flag`, `sat_flag`) is high.
- R4: `irq` is the combinational OR of the five enabled conditions of R1 to R3. With bits 0 to 4 all clear, `irq` stays low whatever the flags are.
- R5: A write while `run_active` is 1 leaves bits 5 and 6 unchanged. A write while `run_active` is 0 loads them.
- R6: `dma_rd_req` equals bit 5 AND NOT `y_empty`. `dma_wr_req` equals bit 6 AND NOT `x1_full`. Both are combinational.
- R7: A write with bit 8 set, made in ST_IDLE, drives `unit_clear` high for exactly the following cycle. The pulse changes none of bits 0 to 7.
- R8: Bit 8 reads 1 only during the `unit_clear` cycle and reads 0 in the cycle after it. A reset-bit write made during the pulse cycle does not start another pulse.
- R9: `clip_en` equals bit 7: 0 selects wrap-around, 1 selects saturation to the largest positive or most negative q1.15 value.
- R10: After `rst_n`, all bits read 0. Bits 9 and up always read 0 and ignore writes.
- R11: A write updates bits 0 to 7 (subject to R5) on the clock edge that samples `wr_en`. Without `wr_en` they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Current register contents |
| run_active | input | 1 | START bit of the parameter register |
| y_empty | input | 1 | Y buffer empty flag |
| x1_full | input | 1 | X1 buffer full flag |
| ovf_flag | input | 1 | Overflow error flag |
| unf_flag | input | 1 | Underflow error flag |
| sat_flag | input | 1 | Saturation error flag |
| irq | output | 1 | Combined interrupt request |
| dma_rd_req | output | 1 | DMA read-channel request |
| dma_wr_req | output | 1 | DMA write-channel request |
| clip_en | output | 1 | Accumulator clip-mode select |
| unit_clear | output | 1 | One-cycle unit reset pulse |

## Verification
`irq`, `dma_rd_req` and `dma_wr_req` are due in the same cycle as a flag change: zero register stages separate a flag input from these outputs. A register write, the DMA lock decision and the start of the reset pulse all take effect one edge after the strobe. Bit 8 and `unit_clear` then fall one further edge later. The bench drives every input just after a falling edge and compares all outputs a moment later, before the next rising edge. It keeps a reference model whose state advances once per rising edge, so each expected value belongs to exactly the cycle in which it is sampled.

// File: rtl/fxa_ctrl_pkg.sv
package fxa_ctrl_pkg;

    // Bit positions inside the control word
    localparam int unsigned BIT_RD_IE  = 0;
    localparam int unsigned BIT_WR_IE  = 1;
    localparam int unsigned BIT_OVF_IE = 2;
    localparam int unsigned BIT_UNF_IE = 3;
    localparam int unsigned BIT_SAT_IE = 4;
    localparam int unsigned BIT_DMAR   = 5;
    localparam int unsigned BIT_DMAW   = 6;
    localparam int unsigned BIT_CLIP   = 7;
    localparam int unsigned BIT_UCLR   = 8;

    localparam int unsigned ENA_W      = 8;   // stored enable bits
    localparam int unsigned CTRL_USED  = 9;   // implemented bits incl. reset
    localparam int unsigned NUM_IRQ    = 5;

    // DMA enables are write-locked during a run
    localparam logic [ENA_W-1:0] LOCK_MASK = (ENA_W'(1) << BIT_DMAR) | (ENA_W'(1) << BIT_DMAW);

    typedef struct packed {
        logic clip;
        logic dmaw;
        logic dmar;
        logic sat_ie;
        logic unf_ie;
        logic ovf_ie;
        logic wr_ie;
        logic rd_ie;
    } ctrl_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CLEAR = 1'b1
    } clr_state_t;

endpackage

// File: rtl/fxa_ctrl_regs.sv
module fxa_ctrl_regs
    import fxa_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ENA_W-1:0] wr_bits,
    input  logic             run_active,
    output ctrl_t            ctrl_q
);

    logic [ENA_W-1:0] keep_mask;
    logic [ENA_W-1:0] ctrl_nxt;

    // Locked bits keep the stored value while a run is active
    always_comb begin
        keep_mask = run_active ? LOCK_MASK : '0;
        ctrl_nxt  = (ctrl_q & keep_mask) | (wr_bits & ~keep_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(ctrl_nxt);
        end
    end

    AST_DMA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run_active) |=> ($stable(ctrl_q.dmar) && $stable(ctrl_q.dmaw))); // R5

    AST_DMA_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !run_active) |=> (ctrl_q.dmar == $past(wr_bits[BIT_DMAR]))); // R5

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q)); // R11

    AST_CLIP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q.clip == $past(wr_bits[BIT_CLIP]))); // R9

endmodule

// File: rtl/fxa_ctrl_rstseq.sv
module fxa_ctrl_rstseq
    import fxa_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic clr_req,
    output logic unit_clear
);

    clr_state_t state_q;
    clr_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_HOLD, T_ARM, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = (wr_en && clr_req) ? ST_CLEAR : ST_IDLE;
            ST_CLEAR: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unit_clear = 1'b0;
        unique case (state_q)
            ST_IDLE:  unit_clear = 1'b0;
            ST_CLEAR: unit_clear = 1'b1;
            default:  unit_clear = 1'b0;
        endcase
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_clear |=> !unit_clear); // R8

    AST_PULSE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_clear && wr_en && clr_req) |=> unit_clear); // R7

    AST_NO_PULSE_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_req) |=> !unit_clear); // R7

endmodule

// File: rtl/fxa_ctrl_reqgen.sv
module fxa_ctrl_reqgen
    import fxa_ctrl_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  y_empty,
    input  logic  x1_full,
    input  logic  ovf_flag,
    input  logic  unf_flag,
    input  logic  sat_flag,
    output logic  irq,
    output logic  dma_rd_req,
    output logic  dma_wr_req
);

    logic [NUM_IRQ-1:0] cond;
    logic [NUM_IRQ-1:0] ena;
    logic [NUM_IRQ-1:0] src;

    always_comb begin
        cond = {sat_flag, unf_flag, ovf_flag, !x1_full, !y_empty};
        ena  = {ctrl.sat_ie, ctrl.unf_ie, ctrl.ovf_ie, ctrl.wr_ie, ctrl.rd_ie};
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        assign src[i] = ena[i] & cond[i];
    end

    assign irq        = |src;
    assign dma_rd_req = ctrl.dmar & ~y_empty;
    assign dma_wr_req = ctrl.dmaw & ~x1_full;

endmodule

// File: rtl/fxa_ctrl.sv
module fxa_ctrl
    import fxa_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              run_active,
    input  logic              y_empty,
    input  logic              x1_full,
    input  logic              ovf_flag,
    input  logic              unf_flag,
    input  logic              sat_flag,
    output logic              irq,
    output logic              dma_rd_req,
    output logic              dma_wr_req,
    output logic              clip_en,
    output logic              unit_clear
);

    localparam int unsigned PAD_W = DATA_W - CTRL_USED;

    ctrl_t ctrl_q;
    logic  wr_data_unused;

    assign wr_data_unused = ^wr_data[DATA_W-1:CTRL_USED];

    fxa_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bits    (wr_data[ENA_W-1:0]),
        .run_active (run_active),
        .ctrl_q     (ctrl_q)
    );

    fxa_ctrl_rstseq u_rstseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .clr_req    (wr_data[BIT_UCLR]),
        .unit_clear (unit_clear)
    );

    fxa_ctrl_reqgen u_reqgen (
        .ctrl       (ctrl_q),
        .y_empty    (y_empty),
        .x1_full    (x1_full),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag),
        .sat_flag   (sat_flag),
        .irq        (irq),
        .dma_rd_req (dma_rd_req),
        .dma_wr_req (dma_wr_req)
    );

    assign rd_data = {{PAD_W{1'b0}}, unit_clear, ctrl_q};
    assign clip_en = ctrl_q.clip;

    AST_RD_REQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        y_empty |-> !dma_rd_req); // R6

    AST_WR_REQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        x1_full |-> !dma_wr_req); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_SAT_IE:BIT_RD_IE] == '0) |-> !irq); // R4

    AST_RD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_RD_IE] && !y_empty) |-> irq); // R1

    AST_WR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_WR_IE] && !x1_full) |-> irq); // R2

    AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data[BIT_OVF_IE] && ovf_flag) || (rd_data[BIT_UNF_IE] && unf_flag)
         || (rd_data[BIT_SAT_IE] && sat_flag)) |-> irq); // R3

    AST_CLEAR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_clear && !wr_en) |=> $stable(ctrl_q)); // R7

endmodule

// File: tb/fxa_ctrl_test.sv
`timescale 1ns/1ps
module fxa_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        run_active = 1'b0;
    logic        y_empty = 1'b1;
    logic        x1_full = 1'b1;
    logic        ovf_flag = 1'b0;
    logic        unf_flag = 1'b0;
    logic        sat_flag = 1'b0;
    logic        irq, dma_rd_req, dma_wr_req, clip_en, unit_clear;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    // Reference model state
    logic [7:0]  m_en  = '0;
    logic        m_clr = 1'b0;

    always #2.5 clk = ~clk;

    fxa_ctrl #(.DATA_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .run_active(run_active), .y_empty(y_empty), .x1_full(x1_full),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag), .sat_flag(sat_flag),
        .irq(irq), .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req),
        .clip_en(clip_en), .unit_clear(unit_clear)
    );

    function automatic logic f_irq(input logic [7:0] en, input logic ye, input logic xf,
                                   input logic ov, input logic un, input logic sa);
        return (en[0] && !ye) || (en[1] && !xf) || (en[2] && ov) || (en[3] && un) || (en[4] && sa);
    endfunction

    function automatic logic [7:0] f_next(input logic [7:0] en, input logic [31:0] wd, input logic run);
        logic [7:0] r;
        r = wd[7:0];
        if (run) begin
            r[5] = en[5];
            r[6] = en[6];
        end
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input logic we, input logic [31:0] wd, input logic run,
                         input logic ye, input logic xf, input logic ov,
                         input logic un, input logic sa);
        @(negedge clk);
        wr_en = we; wr_data = wd; run_active = run;
        y_empty = ye; x1_full = xf; ovf_flag = ov; unf_flag = un; sat_flag = sa;
        #1;
        chk({31'b0, irq}, {31'b0, f_irq(m_en, ye, xf, ov, un, sa)}, "R1/R2/R3/R4 irq");
        chk({31'b0, dma_rd_req}, {31'b0, m_en[5] && !ye}, "R6 dma_rd_req");
        chk({31'b0, dma_wr_req}, {31'b0, m_en[6] && !xf}, "R6 dma_wr_req");
        chk({31'b0, clip_en}, {31'b0, m_en[7]}, "R9 clip_en");
        chk({31'b0, unit_clear}, {31'b0, m_clr}, "R7 unit_clear");
        chk(rd_data, {23'b0, m_clr, m_en}, "R5/R8/R10/R11 rd_data");
        // advance model to the state after the coming rising edge
        if (we) m_en = f_next(m_en, wd, run);
        m_clr = !m_clr && we && wd[8];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1F2E3D4C);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state, all flags active
        apply(0, 0, 0, 0, 0, 1, 1, 1);
        // R10: unused upper bits ignore writes
        apply(1, 32'hFFFF_FE00, 0, 1, 1, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 1, 1, 1);
        // R1: read irq follows y_empty
        apply(1, 32'h01, 0, 1, 1, 0, 0, 0);
        apply(0, 0, 0, 0, 1, 0, 0, 0);
        apply(0, 0, 0, 1, 1, 0, 0, 0);
        // R2: write irq follows x1_full
        apply(1, 32'h02, 0, 1, 1, 0, 0, 0);
        apply(0, 0, 0, 1, 0, 0, 0, 0);
        apply(0, 0, 0, 1, 1, 0, 0, 0);
        // R3: each error enable against each flag
        for (int b = 2; b <= 4; b++) begin
            apply(1, 32'(1) << b, 0, 1, 1, 0, 0, 0);
            apply(0, 0, 0, 1, 1, 1, 0, 0);
            apply(0, 0, 0, 1, 1, 0, 1, 0);
            apply(0, 0, 0, 1, 1, 0, 0, 1);
        end
        // R4: no enables, every condition active
        apply(1, 32'h60, 0, 0, 0, 1, 1, 1);
        apply(0, 0, 0, 0, 0, 1, 1, 1);
        // R6: dma requests against occupancy
        apply(0, 0, 0, 1, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 1, 0, 0, 0);
        // R5: locked during a run, loaded when idle
        apply(1, 32'h00, 1, 0, 0, 0, 0, 0);
        apply(0, 0, 1, 0, 0, 0, 0, 0);
        apply(1, 32'h00, 0, 0, 0, 0, 0, 0);
        apply(1, 32'h40, 1, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0, 0, 0);
        // R9: clip select both ways
        apply(1, 32'h80, 0, 1, 1, 0, 0, 0);
        apply(1, 32'h00, 0, 1, 1, 0, 0, 0);
        // R7/R8: reset pulse with other bits, retrigger in pulse cycle ignored
        apply(1, 32'h1A5, 0, 1, 1, 0, 0, 0);
        apply(1, 32'h1A5, 0, 1, 1, 0, 0, 0);
        apply(0, 0, 0, 1, 1, 0, 0, 0);
        apply(0, 0, 0, 1, 1, 0, 0, 0);
        // R11: held without a strobe
        apply(0, 32'hFF, 0, 0, 0, 1, 1, 1);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            wd = $urandom;
            if (($urandom % 8) != 0) wd[8] = 1'b0;
            apply(($urandom % 3) == 0, wd, ($urandom % 2) == 0,
                  ($urandom % 2) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
                  ($urandom % 4) == 0, ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule